// File: doc/BRIEF.md
# Single-Key Lockout Keyboard Encoder

This block watches the raw, active-high contact lines of a 63-key switch array. It turns a single, steadily held key into a 6-bit key code. A one-cycle strobe tells the consumer that a new code is ready. The strobe is held back until the key has stayed unchanged for a programmable number of clock cycles, so contact bounce cannot produce a false entry.

The encoder enforces strict one-key-at-a-time entry. A chord of two or more keys is never resolved by priority. It is refused, a reject flag is raised, and nothing more is accepted until every key is up again. After a code is issued, the encoder ignores the held key until all keys are released. Each physical press therefore yields at most one code.

The contact lines are asynchronous to the clock, so they pass through a synchronizer of parameterised depth before any decision is made. All latencies below are counted from the clock edge after which the key lines change.

Top module: `key_lockout_encoder`

## Requirements
- R1: While `rst_n` is low, `code_o` is 0, `strobe_o` is 0 and `reject_o` is 0.
- R2: Key line `keys_i[i]` is encoded as code `i+1`, so codes run from 1 to 63 and code 0 means no key. `code_o` changes only together with a strobe and keeps the last issued code afterwards.
- R3: A single key held unchanged produces exactly one `strobe_o` pulse, one cycle wide. The pulse comes SYNC_STAGES + DEBOUNCE_CYCLES + 1 cycles after the key lines changed to that key.
- R4: If the key lines become all-zero before the debounce interval completes, no strobe is issued. A later steady press is timed from its own last change.
- R5: If a different single key replaces the candidate during the interval, timing restarts. Only the new key is strobed, with the R3 latency measured from the change.
- R6: Two or more keys closed together, whether the encoder is idle or the interval is running, produce no strobe. `reject_o` rises SYNC_STAGES + 1 cycles after the change and stays high until all keys have been released.
- R7: After a strobe, no further strobe is issued until all key lines have been zero. This holds however long the key is held.
- R8: Adding a second key while the strobed key is still held raises `reject_o`. Releasing only one of the two keys does not clear `reject_o` and does not produce a strobe.
- R9: After a full release, a fresh press is accepted and encoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_i | input | NUM_KEYS (63) | Raw key contact lines, 1 = closed |
| code_o | output | CODE_W (6) | Last issued key code, 0 = none |
| strobe_o | output | 1 | One-cycle pulse marking a new code |
| reject_o | output | 1 | High while a multi-key press locks the encoder |

## Verification
On every cycle, the bound checker confirms several properties. A strobe only appears after the synchronized lines have held the same single key for the full debounce count. The issued code matches the key that was held. A second strobe never comes without an intervening all-release. The reject flag cannot drop while any key is still closed. The exact strobe cycle, the restart on a key change, the bounce-shortened presses that must stay silent, and the partial release during a chord lockout can only be shown by the bench's timed scenarios. There, a scoreboard pairs each expected code and cycle with the strobe that actually appears.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HELD   = 2'd2,
        ST_LOCK   = 2'd3
    } kbd_state_e;
endpackage

// File: rtl/kbd_input_sync.sv
module kbd_input_sync #(
    parameter int WIDTH  = 63,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_key_census.sv
module kbd_key_census #(
    parameter int NUM_KEYS = 63,
    parameter int CODE_W   = 6
) (
    input  logic [NUM_KEYS-1:0] keys,
    output logic                none,
    output logic                single,
    output logic                multi,
    output logic [CODE_W-1:0]   code
);
    logic              any_seen;
    logic              many_seen;
    logic [CODE_W-1:0] idx_acc;

    always_comb begin
        any_seen  = 1'b0;
        many_seen = 1'b0;
        idx_acc   = '0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (keys[i]) begin
                many_seen = many_seen | any_seen;
                any_seen  = 1'b1;
                idx_acc   = idx_acc | CODE_W'(i + 1);
            end
        end
    end

    assign none   = !any_seen;
    assign multi  = many_seen;
    assign single = any_seen && !many_seen;
    assign code   = single ? idx_acc : '0;
endmodule

// File: rtl/kbd_settle_timer.sv
module kbd_settle_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (!done) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/key_lockout_encoder.sv
module key_lockout_encoder
    import kbd_pkg::*;
#(
    parameter int NUM_KEYS        = 63,
    parameter int CODE_W          = $clog2(NUM_KEYS + 1),
    parameter int DEBOUNCE_CYCLES = 1000000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] keys_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                strobe_o,
    output logic                reject_o
);
    typedef struct packed {
        kbd_state_e        state;
        logic [CODE_W-1:0] cand;
        logic [CODE_W-1:0] code;
        logic              strobe;
    } enc_regs_t;

    logic [NUM_KEYS-1:0] keys_sync;
    logic                k_none, k_single, k_multi;
    logic [CODE_W-1:0]   k_code;
    logic                tmr_run, tmr_done;
    enc_regs_t           r_d, r_q;

    kbd_input_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(keys_i), .dout(keys_sync)
    );

    kbd_key_census #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_census (
        .keys(keys_sync), .none(k_none), .single(k_single),
        .multi(k_multi), .code(k_code)
    );

    assign tmr_run = (r_q.state == ST_SETTLE) && k_single && (k_code == r_q.cand);

    kbd_settle_timer #(.LIMIT(DEBOUNCE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .done(tmr_done)
    );

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (k_multi) begin
                    r_d.state = ST_LOCK;
                end else if (k_single) begin
                    r_d.state = ST_SETTLE;
                    r_d.cand  = k_code;
                end
            end
            ST_SETTLE: begin
                if (k_multi) begin
                    r_d.state = ST_LOCK;
                end else if (k_none) begin
                    r_d.state = ST_IDLE;
                end else if (k_code != r_q.cand) begin
                    r_d.cand = k_code;
                end else if (tmr_done) begin
                    r_d.strobe = 1'b1;
                    r_d.code   = r_q.cand;
                    r_d.state  = ST_HELD;
                end
            end
            ST_HELD: begin
                if (k_multi)     r_d.state = ST_LOCK;
                else if (k_none) r_d.state = ST_IDLE;
            end
            ST_LOCK: begin
                if (k_none) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.cand   <= '0;
            r_q.code   <= '0;
            r_q.strobe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o   = r_q.code;
    assign strobe_o = r_q.strobe;
    assign reject_o = (r_q.state == ST_LOCK);
endmodule

// File: rtl/kbd_encoder_chk.sv
module kbd_encoder_chk #(
    parameter int NUM_KEYS        = 63,
    parameter int CODE_W          = 6,
    parameter int DEBOUNCE_CYCLES = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_KEYS-1:0] key_sync,
    input logic [CODE_W-1:0]   code_o,
    input logic                strobe_o,
    input logic                reject_o
);
    localparam int HW = $clog2(DEBOUNCE_CYCLES + 1);

    logic [NUM_KEYS-1:0] prev_q;
    logic [HW-1:0]       held_q;
    logic                armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            held_q  <= '0;
            armed_q <= 1'b1;
        end else begin
            prev_q <= key_sync;
            if ($countones(key_sync) == 1 && key_sync == prev_q) begin
                if (held_q != HW'(DEBOUNCE_CYCLES)) held_q <= held_q + 1'b1;
            end else begin
                held_q <= '0;
            end
            if (key_sync == '0)  armed_q <= 1'b1;
            else if (strobe_o)   armed_q <= 1'b0;
        end
    end

    p_settled_before_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (held_q >= HW'(DEBOUNCE_CYCLES)));

    p_code_matches_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (code_o != '0 && int'(code_o) <= NUM_KEYS &&
                      $past(key_sync) == (NUM_KEYS'(1) << (code_o - 1'b1))));

    p_one_per_press_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> armed_q);

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    p_lock_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_o && key_sync != '0) |=> reject_o);

    p_no_strobe_in_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> !strobe_o);
endmodule

bind key_lockout_encoder kbd_encoder_chk #(
    .NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .key_sync(keys_sync),
    .code_o(code_o), .strobe_o(strobe_o), .reject_o(reject_o)
);

// File: tb/sim_key_lockout_encoder.sv
module sim_key_lockout_encoder;
    localparam int NK   = 63;
    localparam int CW   = 6;
    localparam int DEB  = 16;
    localparam int SYN  = 2;
    localparam int LAT  = SYN + DEB + 1;

    typedef struct {
        int    code;
        int    at;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NK-1:0] keys = '0;
    logic [CW-1:0] code_o;
    logic          strobe_o, reject_o;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   strobes = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    key_lockout_encoder #(.NUM_KEYS(NK), .DEBOUNCE_CYCLES(DEB), .SYNC_STAGES(SYN)) u0 (
        .clk(clk), .rst_n(rst_n), .keys_i(keys),
        .code_o(code_o), .strobe_o(strobe_o), .reject_o(reject_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [NK-1:0] k, input int exp_code, input string req);
        exp_t e;
        keys = k;
        if (exp_code > 0) begin
            e.code = exp_code; e.at = cyc + LAT; e.req = req;
            q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NK-1:0] key(input int i);
        return NK'(1) << i;
    endfunction

    // monitor: pop expected items as strobes appear
    always @(negedge clk) begin
        if (rst_n && strobe_o) begin
            strobes++;
            if (q.size() == 0) begin
                chk("R7", "unexpected strobe, code", int'(code_o), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "strobe code", int'(code_o), e.code);
                chk(e.req, "strobe cycle", cyc, e.at);
            end
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int s0;
        idle(3);
        chk("R1", "code in reset", int'(code_o), 0);
        chk("R1", "strobe in reset", int'(strobe_o), 0);
        chk("R1", "reject in reset", int'(reject_o), 0);
        rst_n = 1'b1;
        idle(4);

        // R2 / R3: lowest and highest keys
        apply(key(0), 1, "R3");
        idle(LAT + 10);
        apply('0, 0, "");
        idle(8);
        apply(key(62), 63, "R2");
        idle(LAT + 10);
        apply('0, 0, "");
        idle(8);
        chk("R2", "code held after release", int'(code_o), 63);

        // R4: short press never strobes; chatter then steady press
        s0 = strobes;
        apply(key(5), 0, "");
        idle(DEB - 4);
        apply('0, 0, "");
        idle(LAT + 8);
        chk("R4", "strobes after short press", strobes - s0, 0);
        apply(key(5), 0, "");
        idle(3);
        apply('0, 0, "");
        idle(1);
        apply(key(5), 6, "R4");
        idle(LAT + 6);
        apply('0, 0, "");
        idle(8);

        // R5: candidate replaced mid-interval
        s0 = strobes;
        apply(key(3), 0, "");
        idle(8);
        apply(key(9), 10, "R5");
        idle(LAT + 6);
        apply('0, 0, "");
        idle(8);
        chk("R5", "strobes for replaced key", strobes - s0, 1);

        // R6: chord from idle
        s0 = strobes;
        apply(key(1) | key(2), 0, "");
        idle(SYN);
        chk("R6", "reject before sync", int'(reject_o), 0);
        idle(1);
        chk("R6", "reject after chord", int'(reject_o), 1);
        idle(LAT + 4);
        chk("R6", "reject while chord held", int'(reject_o), 1);
        apply('0, 0, "");
        idle(SYN + 1);
        chk("R6", "reject after release", int'(reject_o), 0);
        // R6: chord during settle interval
        apply(key(4), 0, "");
        idle(5);
        apply(key(4) | key(7), 0, "");
        idle(SYN + 1);
        chk("R6", "reject chord in settle", int'(reject_o), 1);
        idle(LAT);
        apply('0, 0, "");
        idle(8);
        chk("R6", "strobes during chords", strobes - s0, 0);

        // R7: long hold yields one strobe
        s0 = strobes;
        apply(key(20), 21, "R7");
        idle(200);
        chk("R7", "strobes for long hold", strobes - s0, 1);

        // R8: second key while held, partial release
        apply(key(20) | key(21), 0, "");
        idle(SYN + 1);
        chk("R8", "reject on added key", int'(reject_o), 1);
        idle(10);
        apply(key(20), 0, "");
        idle(LAT + 6);
        chk("R8", "reject after partial release", int'(reject_o), 1);
        chk("R8", "no strobe after partial release", strobes - s0, 1);
        apply('0, 0, "");
        idle(SYN + 1);
        chk("R8", "reject after full release", int'(reject_o), 0);
        idle(6);

        // R9: fresh press after lock
        apply(key(40), 41, "R9");
        idle(LAT + 4);
        apply('0, 0, "");
        idle(10);
        chk("R9", "code after fresh press", int'(code_o), 41);
        chk("R3", "pending expected strobes", q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule